// File: doc/BRIEF.md
# I3C Target In-Band Interrupt Sequencer

This block lets an I3C target ask the controller for attention by raising an in-band interrupt. When a request is pending and the bus has been idle, a START from the controller starts an attempt. The target then puts its own 7-bit dynamic address on SDA in open-drain fashion, with the most significant bit first, and follows it with a read bit of 1. If another device pulls the line low while this target is releasing it, the target has lost arbitration. It stops driving and reports the loss, and the request stays pending for a later try.

After the 8-bit header, the target samples the controller's acknowledge. A NACK sends the block to a passive wait. An ACK with a payload flagged starts a push-pull transmission of one payload byte, most significant bit first, followed by a ninth end-of-data bit driven low. An ACK with no payload ends the target's part of the transfer at once. A STOP aborts any state. SCL and SDA arrive asynchronously and are synchronized to a system clock that runs at least four times faster than SCL. All SDA drive changes are timed from detected SCL falling edges.

Top module: `ibi_seq_top`

## Requirements
- R1: After reset, `sda_oe` and `sda_pp` are 0 and all three strobes are 0.
- R2: A START (SDA falling while SCL high) seen while `ibi_req` is 1 and no transfer is in progress makes the block put the header `{dyn_addr, 1'b1}` on SDA over the next 8 SCL periods, MSB first, one bit per SCL low phase. The drive is open-drain: `sda_oe` is 1 only for 0 bits, and `sda_pp` stays 0.
- R3: A START seen while `ibi_req` is 0, or a repeated START inside a transfer that is already running, never causes SDA to be driven.
- R4: If the block releases SDA for a header 1 bit and SDA reads 0 during SCL high, it drives nothing for the rest of the transfer. It pulses `ibi_lost` for one clock and does not pulse `ibi_done`.
- R5: If SDA is high during SCL high of the ninth bit after the header (NACK), the block pulses `ibi_nacked` once, sends no payload and drives nothing until STOP.
- R6: If SDA is low in that ninth bit (ACK), and `ibi_req` and `ibi_has_data` are both 1, the block drives `ibi_data` push-pull (`sda_pp`=1), MSB first, over the next 8 SCL periods. It then drives a ninth end-of-data bit of 0 push-pull.
- R7: An ACK while `ibi_has_data` is 0 makes the block release SDA and pulse `ibi_done` once. No payload follows.
- R8: After the end-of-data bit, the next SCL falling edge releases SDA and pulses `ibi_done` for exactly one clock.
- R9: A STOP (SDA rising while SCL high) returns the block to idle from any state, so that a following START with `ibi_req` set starts a new attempt.
- R10: The SDA drive (`sda_oe`, and the level driven when enabled) changes only in response to an SCL falling edge, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| dyn_addr | input | 7 | Target dynamic address |
| ibi_req | input | 1 | Interrupt request pending |
| ibi_has_data | input | 1 | A payload byte follows an accepted request |
| ibi_data | input | 8 | Payload byte |
| sda_oe | output | 1 | SDA driver enable |
| sda_out | output | 1 | SDA level when driven |
| sda_pp | output | 1 | 1 = push-pull drive, 0 = open-drain |
| ibi_done | output | 1 | One-clock pulse: request completed |
| ibi_lost | output | 1 | One-clock pulse: arbitration lost |
| ibi_nacked | output | 1 | One-clock pulse: controller refused |

## Verification
A wrong bit counter or a wrong shift register shows up on the wired-AND line within one SCL period. It appears as a header or payload byte that is shifted or corrupted, and this is compared against the byte computed in the bench. A wrong arbitration decision corrupts the winner's header at the first bit where the two addresses differ. A wrong acknowledge branch shows up nine SCL periods later as payload bits where the line should stay high, or as the reverse, and as a wrong strobe count. A state left stuck after STOP appears as a missing header on the next attempt, within the first SCL low phase after its START.

// File: rtl/ibi_pkg.sv
`timescale 1ns/1ps
package ibi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARB  = 3'd1,
    ST_MACK = 3'd2,
    ST_DATA = 3'd3,
    ST_EOD  = 3'd4,
    ST_WAIT = 3'd5
  } seq_state_t;
endpackage

// File: rtl/ibi_bus_sampler.sv
`timescale 1ns/1ps
module ibi_bus_sampler #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_N-1:0] scl_sync, sda_sync;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_N-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_N-2:0], sda_in};
      scl_p    <= scl_sync[SYNC_N-1];
      sda_p    <= sda_sync[SYNC_N-1];
    end
  end

  assign scl_s    = scl_sync[SYNC_N-1];
  assign sda_s    = sda_sync[SYNC_N-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/ibi_bit_shifter.sv
`timescale 1ns/1ps
module ibi_bit_shifter #(
  parameter int W     = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [W-1:0]     load_val,
  input  logic             shift,
  output logic             msb,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '1;
      count  <= '0;
    end else if (load) begin
      data_q <= load_val;
      count  <= '0;
    end else if (shift) begin
      data_q <= {data_q[W-2:0], 1'b1};
      count  <= count + 1'b1;
    end
  end

  assign msb = data_q[W-1];
endmodule

// File: rtl/ibi_seq_fsm.sv
`timescale 1ns/1ps
module ibi_seq_fsm
  import ibi_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SH_W   = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] dyn_addr,
  input  logic              ibi_req,
  input  logic              ibi_has_data,
  input  logic [DATA_W-1:0] ibi_data,
  input  logic              sh_msb,
  input  logic [CNT_W-1:0]  sh_count,
  output logic              sh_load,
  output logic [SH_W-1:0]   sh_load_val,
  output logic              sh_shift,
  output logic              sda_oe,
  output logic              sda_out,
  output logic              sda_pp,
  output logic              ibi_done,
  output logic              ibi_lost,
  output logic              ibi_nacked
);
  localparam int HDR_W = ADDR_W + 1;

  seq_state_t state;
  logic bus_busy, drv_bit, ack_bit;
  logic hdr_load, dat_load, hdr_full, dat_full, take_payload;
  logic [SH_W-1:0] hdr_word, dat_word;

  assign hdr_word     = SH_W'({dyn_addr, 1'b1}) << (SH_W - HDR_W);
  assign dat_word     = SH_W'(ibi_data) << (SH_W - DATA_W);
  assign hdr_full     = (sh_count == CNT_W'(HDR_W));
  assign dat_full     = (sh_count == CNT_W'(DATA_W));
  assign take_payload = ibi_req & ibi_has_data & ~ack_bit;

  always_comb begin
    hdr_load    = (state == ST_IDLE) && start_ev && !bus_busy && ibi_req && !stop_ev;
    dat_load    = (state == ST_MACK) && scl_rise && !stop_ev;
    sh_load     = hdr_load | dat_load;
    sh_load_val = hdr_load ? hdr_word : dat_word;
    sh_shift    = !stop_ev && scl_fall &&
                  (((state == ST_ARB)  && !hdr_full) ||
                   ((state == ST_DATA) && !dat_full) ||
                   ((state == ST_MACK) && take_payload));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bus_busy   <= 1'b0;
      drv_bit    <= 1'b1;
      ack_bit    <= 1'b1;
      sda_oe     <= 1'b0;
      sda_out    <= 1'b1;
      sda_pp     <= 1'b0;
      ibi_done   <= 1'b0;
      ibi_lost   <= 1'b0;
      ibi_nacked <= 1'b0;
    end else begin
      ibi_done   <= 1'b0;
      ibi_lost   <= 1'b0;
      ibi_nacked <= 1'b0;
      if (start_ev) bus_busy <= 1'b1;
      if (stop_ev)  bus_busy <= 1'b0;
      if (stop_ev) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        sda_out <= 1'b1;
        sda_pp  <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: if (hdr_load) state <= ST_ARB;
          ST_ARB: begin
            if (scl_rise && sh_count != '0 && drv_bit && !sda_s) begin
              ibi_lost <= 1'b1;
              state    <= ST_WAIT;
            end else if (scl_fall) begin
              if (hdr_full) begin
                sda_oe  <= 1'b0;
                sda_out <= 1'b1;
                state   <= ST_MACK;
              end else begin
                sda_oe  <= ~sh_msb;
                sda_out <= 1'b0;
                drv_bit <= sh_msb;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              ack_bit <= sda_s;
            end else if (scl_fall) begin
              if (ack_bit) begin
                ibi_nacked <= 1'b1;
                state      <= ST_WAIT;
              end else if (take_payload) begin
                sda_oe  <= 1'b1;
                sda_pp  <= 1'b1;
                sda_out <= sh_msb;
                state   <= ST_DATA;
              end else begin
                ibi_done <= 1'b1;
                state    <= ST_WAIT;
              end
            end
          end
          ST_DATA: begin
            if (scl_fall) begin
              if (dat_full) begin
                sda_out <= 1'b0;
                state   <= ST_EOD;
              end else begin
                sda_out <= sh_msb;
              end
            end
          end
          ST_EOD: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              sda_pp   <= 1'b0;
              sda_out  <= 1'b1;
              ibi_done <= 1'b1;
              state    <= ST_WAIT;
            end
          end
          ST_WAIT: if (start_ev) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ibi_done, ibi_lost, ibi_nacked})); // R5
  AST_ARB_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARB && $past(state) == ST_IDLE) |-> $past(ibi_req)); // R2
  AST_LOST_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ibi_lost |-> !sda_oe); // R4
  AST_PP_ONLY_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    sda_pp |-> sda_oe); // R6
  AST_NACK_NO_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    ibi_nacked |-> !sda_pp); // R5
  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable({sda_oe, sda_out}) |-> ($past(scl_fall) || $past(stop_ev))); // R10
endmodule

// File: rtl/ibi_seq_top.sv
`timescale 1ns/1ps
module ibi_seq_top #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] dyn_addr,
  input  logic              ibi_req,
  input  logic              ibi_has_data,
  input  logic [DATA_W-1:0] ibi_data,
  output logic              sda_oe,
  output logic              sda_out,
  output logic              sda_pp,
  output logic              ibi_done,
  output logic              ibi_lost,
  output logic              ibi_nacked
);
  localparam int HDR_W = ADDR_W + 1;
  localparam int SH_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic sh_load, sh_shift, sh_msb;
  logic [SH_W-1:0]  sh_load_val;
  logic [CNT_W-1:0] sh_count;

  ibi_bus_sampler #(.SYNC_N(SYNC_N)) u_sampler (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  ibi_bit_shifter #(.W(SH_W), .CNT_W(CNT_W)) u_shifter (
    .clk(clk), .rst(rst), .load(sh_load), .load_val(sh_load_val),
    .shift(sh_shift), .msb(sh_msb), .count(sh_count)
  );

  ibi_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SH_W(SH_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s),
    .dyn_addr(dyn_addr), .ibi_req(ibi_req), .ibi_has_data(ibi_has_data),
    .ibi_data(ibi_data), .sh_msb(sh_msb), .sh_count(sh_count),
    .sh_load(sh_load), .sh_load_val(sh_load_val), .sh_shift(sh_shift),
    .sda_oe(sda_oe), .sda_out(sda_out), .sda_pp(sda_pp),
    .ibi_done(ibi_done), .ibi_lost(ibi_lost), .ibi_nacked(ibi_nacked)
  );

  logic unused_scl_s;
  assign unused_scl_s = scl_s;
endmodule

// File: tb/ibi_seq_top_bench.sv
`timescale 1ns/1ps
module ibi_seq_top_bench;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, ctrl_sda = 1'b1, other_sda = 1'b1;
  logic [6:0] dyn_addr = '0;
  logic ibi_req = 1'b0, ibi_has_data = 1'b0;
  logic [7:0] ibi_data = '0;
  logic sda_oe, sda_out, sda_pp, ibi_done, ibi_lost, ibi_nacked;
  logic sda_line;
  bit other_active = 0;
  int tests = 0, fails = 0;
  int done_cnt = 0, lost_cnt = 0, nack_cnt = 0, hi_chg = 0;
  logic [1:0] prev_drv = 2'b00;

  always #2.5 clk = ~clk;

  assign sda_line = ctrl_sda & other_sda & (sda_oe ? sda_out : 1'b1);

  ibi_seq_top u_ibi_seq_top (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .dyn_addr(dyn_addr),
    .ibi_req(ibi_req), .ibi_has_data(ibi_has_data), .ibi_data(ibi_data),
    .sda_oe(sda_oe), .sda_out(sda_out), .sda_pp(sda_pp),
    .ibi_done(ibi_done), .ibi_lost(ibi_lost), .ibi_nacked(ibi_nacked)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (ibi_done) done_cnt++;
      if (ibi_lost) lost_cnt++;
      if (ibi_nacked) nack_cnt++;
      if ({sda_oe, sda_oe & sda_out} != prev_drv && scl) hi_chg++;
      prev_drv <= {sda_oe, sda_oe & sda_out};
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    ctrl_sda = 1'b1; scl = 1'b1; wait_n(H);
    ctrl_sda = 1'b0; wait_n(H);
  endtask

  task automatic do_stop();
    scl = 1'b0; ctrl_sda = 1'b0; wait_n(H);
    scl = 1'b1; wait_n(H);
    ctrl_sda = 1'b1; wait_n(H);
  endtask

  task automatic do_bit(input logic cbit, input logic obit, output logic lv, output logic pv);
    scl = 1'b0; ctrl_sda = cbit;
    other_sda = other_active ? obit : 1'b1;
    wait_n(H);
    scl = 1'b1; wait_n(H/2);
    lv = sda_line; pv = sda_pp;
    if (other_active && obit && !sda_line) other_active = 0;
    wait_n(H/2);
  endtask

  task automatic run_ibi(input logic [6:0] addr, input bit oth_en, input logic [6:0] oth,
                         input bit ack, input bit has, input logic [7:0] pay, input bit pend);
    logic [7:0] mh, oh, hdr_l, hdr_p, exp_hdr;
    logic [8:0] dat_l, dat_p, exp_dat;
    logic lv, pv;
    bit win;
    int d0, l0, n0;
    mh = {addr, 1'b1}; oh = {oth, 1'b1};
    dyn_addr = addr; ibi_req = pend; ibi_has_data = has; ibi_data = pay;
    d0 = done_cnt; l0 = lost_cnt; n0 = nack_cnt;
    other_active = oth_en;
    do_start();
    for (int i = 7; i >= 0; i--) begin
      do_bit(1'b1, oh[i], lv, pv); hdr_l[i] = lv; hdr_p[i] = pv;
    end
    other_active = 0;
    do_bit(~ack, 1'b1, lv, pv);
    for (int i = 8; i >= 0; i--) begin
      do_bit(1'b1, 1'b1, lv, pv); dat_l[i] = lv; dat_p[i] = pv;
    end
    do_stop();
    win = pend && !(oth_en && oh < mh);
    if (!pend) exp_hdr = oth_en ? oh : 8'hFF;
    else if (oth_en && oh < mh) exp_hdr = oh;
    else exp_hdr = mh;
    exp_dat = (win && ack && has) ? {pay, 1'b0} : 9'h1FF;
    if (!pend) chk("R3 passive header", int'(hdr_l), int'(exp_hdr));
    else if (oth_en) chk("R4 arbitrated header", int'(hdr_l), int'(exp_hdr));
    else chk("R2 header", int'(hdr_l), int'(exp_hdr));
    chk("R2 header open-drain", int'(hdr_p), 0);
    if (win && ack && has) begin
      chk("R6 payload+eod", int'(dat_l), int'(exp_dat));
      chk("R6 payload push-pull", int'(dat_p), 9'h1FF);
      chk("R8 done after eod", done_cnt - d0, 1);
    end else begin
      chk(ack ? "R7 no payload" : "R5 no payload", int'(dat_l), int'(exp_dat));
      chk("R7 done count", done_cnt - d0, (win && ack) ? 1 : 0);
    end
    chk("R4 lost count", lost_cnt - l0, (pend && oth_en && oh < mh) ? 1 : 0);
    chk("R5 nack count", nack_cnt - n0, (win && !ack) ? 1 : 0);
    chk("R9 released after stop", int'(sda_oe), 0);
    if (done_cnt != d0) ibi_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic lv, pv;
    logic [7:0] line_b;
    int l0;
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    chk("R1 reset oe", int'(sda_oe), 0);
    chk("R1 reset pp", int'(sda_pp), 0);
    chk("R1 reset strobes", int'({ibi_done, ibi_lost, ibi_nacked}), 0);

    for (int a = 0; a < 128; a++)
      run_ibi(7'(a), 0, 7'h0, (a % 3) != 0, a[1], 8'(a * 7 + 3), 1);

    for (int a = 0; a < 6; a++)
      run_ibi(7'(a * 21 + 5), a[0], 7'(a * 13), 1, 1, 8'hA5, 0);

    for (int k = 0; k < 14; k++) begin
      logic [6:0] m, o;
      m = 7'(k * 9 + 17);
      o = m ^ 7'(1 << (k % 7));
      run_ibi(m, 1, o, k[0], 1, 8'(k * 29), 1);
    end

    // R3: a repeated START inside a running transfer must not trigger
    l0 = lost_cnt;
    dyn_addr = 7'h12; ibi_req = 1'b0; ibi_has_data = 1'b1;
    do_start();
    ibi_req = 1'b1;
    scl = 1'b0; ctrl_sda = 1'b1; wait_n(H);
    scl = 1'b1; wait_n(H);
    ctrl_sda = 1'b0; wait_n(H);
    for (int i = 7; i >= 0; i--) begin
      do_bit(1'b1, 1'b1, lv, pv); line_b[i] = lv;
    end
    chk("R3 no drive after Sr", int'(line_b), 8'hFF);
    do_stop();
    chk("R3 no strobe", lost_cnt - l0, 0);

    // R9: STOP in the middle of arbitration returns to idle
    dyn_addr = 7'h7F; ibi_req = 1'b1;
    do_start();
    for (int i = 0; i < 3; i++) do_bit(1'b1, 1'b1, lv, pv);
    do_stop();
    chk("R9 abort released", int'(sda_oe), 0);
    run_ibi(7'h2C, 0, 7'h0, 1, 1, 8'h3C, 1);

    chk("R10 drive changed while SCL high", hi_chg, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule